// File: doc/BRIEF.md
# Multi-Path GPIO Output Bank

An eight-channel output register that a processor can update through three independent write paths. A whole-word write replaces every output bit. A masked write carries a select mask and new values in one word, and only the selected bits change. A command write gives each channel a two-bit code that sets, clears or toggles that channel, and several channels can be commanded in one write. All updates land on the next rising clock edge.

A separate enable mask decides which channels the bank drives. Where a channel is enabled, its pin shows the register bit. Where it is disabled, the pin passes through an alternate source supplied from outside. The enable mask is updated with a set-or-clear write and a bit mask. Status ports read back the register levels and the enable mask.

When more than one update path is strobed in the same cycle, only one of them takes effect. The whole-word write wins over the masked write, and the masked write wins over the command write.

Top module: `gpo_multipath_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register levels (`level_o`) and the enable mask (`en_o`) become all zeros.
- R2: A whole-word write (`dir_we`=1) loads `dir_data` into all eight levels at the next edge.
- R3: A masked write (`msk_we`=1) uses `msk_word[7:0]` as the mask and `msk_word[15:8]` as the values. A level whose mask bit is 1 takes its value bit, and every other level keeps its state.
- R4: A command write (`cmd_we`=1) reads the field `cmd_word[2c+1:2c]` for channel c. Code 01 sets the channel, 10 clears it and 11 toggles it.
- R5: Command code 00 leaves its channel unchanged. Channels with non-zero codes in the same word are all updated in that one write.
- R6: When several write paths are strobed in one cycle, only the highest-priority path applies. The order is whole-word, then masked, then command.
- R7: An enable write (`en_we`=1) with `en_set`=1 sets the enable bits that are 1 in `en_bits`. With `en_set`=0 it clears those bits. Enable bits that are 0 in `en_bits` keep their state.
- R8: For each channel c, `gpio_o[c]` equals `level_o[c]` when enable bit c is 1, and equals `alt_i[c]` when it is 0.
- R9: In a cycle with no level write strobe, the levels hold. `level_o` always shows the current register levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_we | input | 1 | Whole-word write strobe |
| dir_data | input | 8 | Whole-word write value |
| msk_we | input | 1 | Masked write strobe |
| msk_word | input | 16 | Mask in [7:0], values in [15:8] |
| cmd_we | input | 1 | Per-channel command write strobe |
| cmd_word | input | 16 | Two-bit command per channel at bit 2c |
| en_we | input | 1 | Enable mask write strobe |
| en_set | input | 1 | 1 sets the selected enable bits, 0 clears them |
| en_bits | input | 8 | Channels touched by the enable write |
| alt_i | input | 8 | Alternate source for channels the bank does not drive |
| gpio_o | output | 8 | Pin values after ownership selection |
| level_o | output | 8 | Readback of the register levels |
| en_o | output | 8 | Readback of the enable mask |

## Verification
The bench targets several corner cases, and each one exposes a specific fault:
- Strobing two or all three update paths in one cycle exposes a wrong priority order or a merge of paths. Such a design would leave bits that the winning write should have set.
- Masked writes with sparse masks and with values that conflict with the current state expose a design that also writes the unmasked bits, or that swaps the mask and value halves.
- Command words that mix 00, set, clear and toggle codes across channels expose a misplaced field or a swapped code meaning.
- A toggle applied twice must restore the original level.
- Changes to the enable mask and to the alternate source show whether the pins take their value from the wrong source.

// File: rtl/gpo_pkg.sv
// Package: shared types for the multi-path output bank.
// Assumes two-bit per-channel command codes; the code values define behaviour.
package gpo_pkg;

    // Per-channel command codes carried in the command word.
    typedef enum logic [1:0] {
        CMD_KEEP   = 2'b00,
        CMD_SET    = 2'b01,
        CMD_CLEAR  = 2'b10,
        CMD_TOGGLE = 2'b11
    } chan_cmd_e;

    // Which write path updates the levels in a given cycle.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_DIRECT = 2'd1,
        SRC_MASKED = 2'd2,
        SRC_CMD    = 2'd3
    } upd_src_e;

    localparam int CMD_W = 2;

endpackage

// File: rtl/gpo_cmd_decode.sv
// Module: gpo_cmd_decode
// Works out the level vector that a command write would produce from the
// current levels. Each channel reads its own two-bit field at bit 2*c.
// Assumes the command word is 2*N bits wide. Purely combinational.
module gpo_cmd_decode
    import gpo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [CMD_W*N-1:0] cmd_word,
    input  logic [N-1:0]       cur_level,
    output logic [N-1:0]       cmd_level
);

    for (genvar c = 0; c < N; c++) begin : g_chan
        chan_cmd_e fld;

        // Extract this channel's command field.
        assign fld = chan_cmd_e'(cmd_word[CMD_W*c +: CMD_W]);

        // Apply the command code to this channel's level.
        always_comb begin
            unique case (fld)
                CMD_SET:    cmd_level[c] = 1'b1;
                CMD_CLEAR:  cmd_level[c] = 1'b0;
                CMD_TOGGLE: cmd_level[c] = ~cur_level[c];
                default:    cmd_level[c] = cur_level[c];
            endcase
        end
    end

endmodule

// File: rtl/gpo_level_reg.sv
// Module: gpo_level_reg
// Holds the output levels. Picks one write path per cycle by fixed priority
// (whole-word, then masked, then command) and registers the result.
// Assumes the command result was computed from the current levels.
module gpo_level_reg
    import gpo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic [N-1:0] dir_data,
    input  logic         msk_we,
    input  logic [N-1:0] msk_sel,
    input  logic [N-1:0] msk_val,
    input  logic         cmd_we,
    input  logic [N-1:0] cmd_level,
    output logic [N-1:0] level_q
);

    upd_src_e     src;
    logic [N-1:0] level_d;

    // Choose the winning write path for this cycle.
    always_comb begin
        if (dir_we)      src = SRC_DIRECT;
        else if (msk_we) src = SRC_MASKED;
        else if (cmd_we) src = SRC_CMD;
        else             src = SRC_HOLD;
    end

    // Form the next level vector from the winning path.
    always_comb begin
        unique case (src)
            SRC_DIRECT: level_d = dir_data;
            SRC_MASKED: level_d = (level_q & ~msk_sel) | (msk_val & msk_sel);
            SRC_CMD:    level_d = cmd_level;
            default:    level_d = level_q;
        endcase
    end

    // Level register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> level_q == '0); // R1
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> level_q == $past(dir_data)); // R2
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_we && !dir_we) |=> ((level_q & ~$past(msk_sel)) == ($past(level_q) & ~$past(msk_sel)))); // R3
    AST_MASK_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_we && !dir_we) |=> ((level_q & $past(msk_sel)) == ($past(msk_val) & $past(msk_sel)))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_we && !msk_we && !cmd_we) |=> $stable(level_q)); // R9

endmodule

// File: rtl/gpo_enable_reg.sv
// Module: gpo_enable_reg
// Per-channel ownership mask. A write either sets or clears the channels
// named in the bit mask; unnamed channels keep their state.
module gpo_enable_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         en_set,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] en_q
);

    logic [N-1:0] en_d;

    // Next enable mask: set or clear the selected bits.
    always_comb begin
        en_d = en_q;
        if (en_we) en_d = en_set ? (en_q | en_bits) : (en_q & ~en_bits);
    end

    // Enable register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    AST_EN_RESET: assert property (@(posedge clk) !rst_n |=> en_q == '0); // R1
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_set) |=> ((en_q & $past(en_bits)) == $past(en_bits))); // R7
    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && !en_set) |=> ((en_q & $past(en_bits)) == '0)); // R7
    AST_EN_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> ((en_q & ~$past(en_bits)) == ($past(en_q) & ~$past(en_bits)))); // R7

endmodule

// File: rtl/gpo_pin_mux.sv
// Module: gpo_pin_mux
// Per-channel ownership select: enabled channels show the bank level,
// disabled channels pass the alternate source. Combinational.
module gpo_pin_mux #(
    parameter int N = 8
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] level,
    input  logic [N-1:0] alt,
    output logic [N-1:0] pin
);

    for (genvar c = 0; c < N; c++) begin : g_pin
        // Select the driver for this pin.
        assign pin[c] = en[c] ? level[c] : alt[c];
    end

endmodule

// File: rtl/gpo_multipath_bank.sv
// Module: gpo_multipath_bank (top)
// Eight-channel output bank with whole-word, masked and per-channel command
// writes, an ownership enable mask, and readback of levels and enables.
// Assumes all strobes are synchronous to clk; reset is synchronous, active low.
module gpo_multipath_bank
    import gpo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_we,
    input  logic [N-1:0]       dir_data,
    input  logic               msk_we,
    input  logic [2*N-1:0]     msk_word,
    input  logic               cmd_we,
    input  logic [CMD_W*N-1:0] cmd_word,
    input  logic               en_we,
    input  logic               en_set,
    input  logic [N-1:0]       en_bits,
    input  logic [N-1:0]       alt_i,
    output logic [N-1:0]       gpio_o,
    output logic [N-1:0]       level_o,
    output logic [N-1:0]       en_o
);

    localparam int VAL_LSB = N;

    logic [N-1:0] level_q;
    logic [N-1:0] cmd_level;
    logic [N-1:0] en_q;
    logic [N-1:0] msk_sel;
    logic [N-1:0] msk_val;

    // Split the masked-write word into its mask and value halves.
    assign msk_sel = msk_word[N-1:0];
    assign msk_val = msk_word[VAL_LSB +: N];

    gpo_cmd_decode #(.N(N)) u_cmd (
        .cmd_word  (cmd_word),
        .cur_level (level_q),
        .cmd_level (cmd_level)
    );

    gpo_level_reg #(.N(N)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_we    (dir_we),
        .dir_data  (dir_data),
        .msk_we    (msk_we),
        .msk_sel   (msk_sel),
        .msk_val   (msk_val),
        .cmd_we    (cmd_we),
        .cmd_level (cmd_level),
        .level_q   (level_q)
    );

    gpo_enable_reg #(.N(N)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .en_set  (en_set),
        .en_bits (en_bits),
        .en_q    (en_q)
    );

    gpo_pin_mux #(.N(N)) u_mux (
        .en    (en_q),
        .level (level_q),
        .alt   (alt_i),
        .pin   (gpio_o)
    );

    // Readback ports.
    assign level_o = level_q;
    assign en_o    = en_q;

    AST_CMD_KEEP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !dir_we && !msk_we && cmd_word == '0) |=> $stable(level_o)); // R5
    AST_CMD_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && dir_we) |=> level_o == $past(dir_data)); // R6

endmodule

// File: tb/tb_gpo_multipath_bank.sv
`timescale 1ns/1ps
module tb_gpo_multipath_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_we = 1'b0;
    logic [7:0]  dir_data = '0;
    logic        msk_we = 1'b0;
    logic [15:0] msk_word = '0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        en_we = 1'b0;
    logic        en_set = 1'b0;
    logic [7:0]  en_bits = '0;
    logic [7:0]  alt_i = '0;
    logic [7:0]  gpio_o, level_o, en_o;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;
    bit done = 1'b0;
    string tag = "R1";

    logic [7:0] m_lvl = '0;
    logic [7:0] m_en  = '0;

    always #2.5 clk = ~clk;

    gpo_multipath_bank dut (
        .clk(clk), .rst_n(rst_n),
        .dir_we(dir_we), .dir_data(dir_data),
        .msk_we(msk_we), .msk_word(msk_word),
        .cmd_we(cmd_we), .cmd_word(cmd_word),
        .en_we(en_we), .en_set(en_set), .en_bits(en_bits),
        .alt_i(alt_i), .gpio_o(gpio_o), .level_o(level_o), .en_o(en_o)
    );

    // Behavioural reference model, one update per rising edge.
    always @(posedge clk) begin
        logic [7:0] t;
        t = m_lvl;
        if (!rst_n) begin
            t = 8'h00;
        end else if (dir_we) begin
            t = dir_data;
        end else if (msk_we) begin
            for (int i = 0; i < 8; i++)
                if (msk_word[i]) t[i] = msk_word[8+i];
        end else if (cmd_we) begin
            for (int i = 0; i < 8; i++) begin
                int code;
                code = cmd_word[2*i +: 2];
                if (code == 1) t[i] = 1'b1;
                else if (code == 2) t[i] = 1'b0;
                else if (code == 3) t[i] = ~m_lvl[i];
            end
        end
        m_lvl <= t;
        if (!rst_n) m_en <= 8'h00;
        else if (en_we) begin
            for (int i = 0; i < 8; i++)
                if (en_bits[i]) m_en[i] <= en_set;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle, shortly after the falling edge.
    always @(negedge clk) begin
        #1;
        if (compare_on) begin
            logic [7:0] pin_exp;
            for (int i = 0; i < 8; i++) pin_exp[i] = m_en[i] ? m_lvl[i] : alt_i[i];
            check(tag, level_o, m_lvl);
            check("R7", en_o, m_en);
            check("R8", gpio_o, pin_exp);
        end
    end

    task automatic strobe(input bit d, input logic [7:0] dv, input bit m, input logic [15:0] mw,
                          input bit c, input logic [15:0] cw);
        @(negedge clk);
        dir_we = d; dir_data = dv; msk_we = m; msk_word = mw; cmd_we = c; cmd_word = cw;
        @(negedge clk);
        dir_we = 0; msk_we = 0; cmd_we = 0;
    endtask

    task automatic en_write(input bit s, input logic [7:0] b);
        @(negedge clk);
        en_we = 1; en_set = s; en_bits = b;
        @(negedge clk);
        en_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with inputs strobed to show reset dominates.
        dir_we = 1; dir_data = 8'hFF; en_we = 1; en_set = 1; en_bits = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1", level_o, 8'h00);
        check("R1", en_o, 8'h00);
        dir_we = 0; en_we = 0;
        @(negedge clk);
        rst_n = 1;
        compare_on = 1;

        // R2: whole-word writes.
        tag = "R2";
        strobe(1, 8'hA5, 0, 0, 0, 0);
        strobe(1, 8'h3C, 0, 0, 0, 0);
        strobe(1, 8'hFF, 0, 0, 0, 0);
        strobe(1, 8'h00, 0, 0, 0, 0);

        // R3: masked writes, including conflicting values on unmasked bits.
        tag = "R3";
        strobe(1, 8'h0F, 0, 0, 0, 0);
        strobe(0, 0, 1, {8'hF0, 8'hC3}, 0, 0);
        strobe(0, 0, 1, {8'h00, 8'hFF}, 0, 0);
        strobe(0, 0, 1, {8'hFF, 8'h00}, 0, 0);
        strobe(0, 0, 1, {8'h5A, 8'h81}, 0, 0);

        // R4: set, clear and toggle in single and mixed words.
        tag = "R4";
        strobe(1, 8'h00, 0, 0, 0, 0);
        strobe(0, 0, 0, 0, 1, 16'h0001);
        strobe(0, 0, 0, 0, 1, 16'h4000);
        strobe(0, 0, 0, 0, 1, 16'h0002);
        strobe(0, 0, 0, 0, 1, 16'hFFFF);
        strobe(0, 0, 0, 0, 1, 16'hFFFF);
        strobe(0, 0, 0, 0, 1, 16'hE4E4);

        // R5: keep codes and several channels per write.
        tag = "R5";
        strobe(0, 0, 0, 0, 1, 16'h0000);
        strobe(0, 0, 0, 0, 1, 16'h9C31);

        // R6: collisions between paths.
        tag = "R6";
        strobe(1, 8'h12, 1, {8'hFF, 8'hFF}, 1, 16'hAAAA);
        strobe(0, 0, 1, {8'h00, 8'h0F}, 1, 16'h5555);
        strobe(1, 8'hC0, 0, 0, 1, 16'hFFFF);
        strobe(1, 8'h81, 1, {8'h7E, 8'hFF}, 0, 0);

        // R7 and R8: ownership changes with a moving alternate source.
        tag = "R9";
        alt_i = 8'h5A;
        en_write(1, 8'h0F);
        alt_i = 8'hC3;
        en_write(1, 8'h30);
        en_write(0, 8'h05);
        alt_i = 8'hFF;
        en_write(0, 8'h00);
        en_write(1, 8'hFF);
        alt_i = 8'h00;
        en_write(0, 8'hF0);

        // R9: idle cycles hold the levels.
        repeat (5) @(negedge clk);

        // Mixed sequence exercising every path together.
        tag = "R6";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            dir_we = ($urandom % 4) == 0; dir_data = 8'($urandom);
            msk_we = ($urandom % 3) == 0; msk_word = 16'($urandom);
            cmd_we = ($urandom % 2) == 0; cmd_word = 16'($urandom);
            en_we = ($urandom % 3) == 0; en_set = 1'($urandom); en_bits = 8'($urandom);
            alt_i = 8'($urandom);
        end
        @(negedge clk);
        dir_we = 0; msk_we = 0; cmd_we = 0; en_we = 0;
        repeat (2) @(negedge clk);

        compare_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule